// File: doc/BRIEF.md
# E&M Signaling Port Controller

This block carries channel-associated E&M signaling between a 4-bit external I/O port and a host-facing message interface. A free-running counter marks a 1 ms grid. On each grid point, once the block is active, it runs a strobed read cycle on the shared external bus to fetch the four E inputs. It then hands the value to the host side with a one-cycle valid pulse, even when the value has not changed. In the other direction, M bits arriving from the host side are held in a register and written to the port with a strobed write cycle.

The external bus is shared with memory accesses. A memory request always wins a free bus, and a memory cycle never overlaps an I/O strobe. An I/O cycle that a memory cycle blocks is started as soon as the memory strobe returns high. The port enable output stays high after reset, which keeps the external output buffers in high impedance. The enable drops low one cycle after a Run command and stays low until the next reset. No I/O cycle of any kind runs while the enable is high.

Top module: `em_sig_port`

## Requirements
- R1: After reset, sigen_n, ios_n and ms_n are high, e_valid is low, mem_gnt is low and the held M value is 0000, so the first write after Run carries 0000 when no M update came in.
- R2: sigen_n goes low in the cycle after run_cmd is sampled high and stays low until reset. While sigen_n is high, ios_n stays high and no e_valid pulse appears, whatever the tick.
- R3: While active, a read strobe is issued every TICK_CYCLES = CLK_HZ/1000 clock cycles on an otherwise idle bus. In the cycle after the strobe ends, e_valid is high for exactly one cycle, and e_bits equals bus_din_lo as sampled on the strobe's second cycle. This happens on every tick, even when the inputs are unchanged.
- R4: Every I/O strobe holds ios_n low for exactly 2 cycles. A read cycle has rw_n high and bus_oe low. A write cycle has rw_n low and bus_oe high.
- R5: m_valid latches m_bits as the held M value, and a write cycle follows that drives the held value on bus_dout[3:0], with bus_dout[15:4] zero. When several updates arrive before the write is issued, the latest one is written.
- R6: When mem_req is high and no I/O strobe is running, ms_n is low and mem_gnt is high in the same cycle. A request that arrives during an I/O strobe waits for the strobe to end. ios_n and ms_n are never low together.
- R7: An I/O cycle that a memory cycle holds off starts its strobe in the first cycle after ms_n returns high.
- R8: When a write and a read are both pending, the write strobe is issued first and the read strobe follows.
- R9: During a memory cycle, bus_addr equals mem_addr, rw_n equals the inverse of mem_wr, bus_oe equals mem_wr, and bus_dout equals mem_wdata on a write.
- R10: Activation by Run queues a write of the held M value, so an M update received before Run reaches the port once the block is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_cmd | input | 1 | Run command; activates the port |
| m_valid | input | 1 | Host-side M update strobe |
| m_bits | input | 4 | M values to drive toward the port |
| e_valid | output | 1 | One-cycle pulse: a new E sample is on e_bits |
| e_bits | output | 4 | Last sampled E inputs |
| mem_req | input | 1 | Memory access request (priority over I/O) |
| mem_wr | input | 1 | Memory access is a write |
| mem_addr | input | 16 | Memory address |
| mem_wdata | input | 16 | Memory write data |
| mem_gnt | output | 1 | Memory cycle granted this cycle |
| sigen_n | output | 1 | Active-low port output enable |
| ios_n | output | 1 | Active-low I/O strobe |
| ms_n | output | 1 | Active-low memory strobe |
| rw_n | output | 1 | High for read, low for write |
| bus_addr | output | 16 | External address bus |
| bus_dout | output | 16 | External data bus, outbound |
| bus_oe | output | 1 | Outbound data bus drive enable |
| bus_din_lo | input | 4 | Low bits of the inbound data bus (E inputs during an I/O read) |

## Verification
On every cycle, the assertions check that the two strobes never overlap, that a free bus goes to memory, that each I/O strobe lasts two cycles, that no strobe runs and the enable stays low once dropped, that the valid pulse lasts one cycle, and that a deferred I/O cycle begins right after the memory strobe rises. Other properties need a scenario in the bench: the exact 1 ms spacing of samples on a quiet bus, the data carried by each write (latest update wins, zero after reset, a pre-Run update sent at activation), write-before-read ordering after a long memory hold, and E values matched against the modeled port pins.

// File: rtl/em_sig_pkg.sv
package em_sig_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_STB1 = 2'd1,
    SEQ_STB2 = 2'd2
  } seq_state_e;

  // An I/O cycle may start only on a free, active bus with work queued
  function automatic logic io_may_start(input seq_state_e st, input logic mem_req,
                                        input logic active, input logic pend);
    return (st == SEQ_IDLE) && !mem_req && active && pend;
  endfunction

  // Memory owns the bus whenever it asks and no strobe is running
  function automatic logic mem_owns_bus(input seq_state_e st, input logic mem_req);
    return (st == SEQ_IDLE) && mem_req;
  endfunction

endpackage

// File: rtl/em_tick_gen.sv
module em_tick_gen #(
  parameter int PERIOD = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/em_run_ctl.sv
module em_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic run_cmd,
  output logic sigen_n,
  output logic activate
);
  // First Run after reset: the port comes alive on the next edge
  assign activate = run_cmd && sigen_n;

  always_ff @(posedge clk) begin
    if (!rst_n)        sigen_n <= 1'b1;
    else if (activate) sigen_n <= 1'b0;
  end
endmodule

// File: rtl/em_bus_seq.sv
module em_bus_seq
  import em_sig_pkg::*;
#(
  parameter int SIG_W = 4,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] IO_ADDR = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             activate,
  input  logic             tick,
  input  logic             m_valid,
  input  logic [SIG_W-1:0] m_bits,
  input  logic             mem_req,
  input  logic             mem_wr,
  input  logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_wdata,
  input  logic [SIG_W-1:0] bus_din_lo,
  output logic             ios_n,
  output logic             ms_n,
  output logic             rw_n,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_dout,
  output logic             bus_oe,
  output logic             mem_gnt,
  output logic             e_valid,
  output logic [SIG_W-1:0] e_bits,
  output logic             io_pend
);
  seq_state_e st;
  logic wr_pend, rd_pend, cur_wr;
  logic [SIG_W-1:0] m_held, wr_data;
  logic io_start, mem_cyc, wr_go, rd_go, strobe_on;

  assign io_pend   = wr_pend || rd_pend;
  assign io_start  = io_may_start(st, mem_req, active, io_pend);
  assign wr_go     = io_start && wr_pend;
  assign rd_go     = io_start && !wr_pend;
  assign mem_cyc   = mem_owns_bus(st, mem_req);
  assign strobe_on = (st != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SEQ_IDLE;
      wr_pend <= 1'b0;
      rd_pend <= 1'b0;
      cur_wr  <= 1'b0;
      m_held  <= '0;
      wr_data <= '0;
      e_valid <= 1'b0;
      e_bits  <= '0;
    end else begin
      if (m_valid) m_held <= m_bits;

      if (wr_go)                       wr_pend <= 1'b0;
      else if (m_valid || activate)    wr_pend <= 1'b1;

      rd_pend <= (rd_pend && !rd_go) || (tick && active);

      unique case (st)
        SEQ_IDLE: if (io_start) begin
          st      <= SEQ_STB1;
          cur_wr  <= wr_pend;
          wr_data <= m_valid ? m_bits : m_held;
        end
        SEQ_STB1: st <= SEQ_STB2;
        default:  st <= SEQ_IDLE;
      endcase

      e_valid <= (st == SEQ_STB2) && !cur_wr;
      if ((st == SEQ_STB2) && !cur_wr) e_bits <= bus_din_lo;
    end
  end

  always_comb begin
    ios_n   = !strobe_on;
    ms_n    = !mem_cyc;
    mem_gnt = mem_cyc;
    if (strobe_on) begin
      rw_n     = !cur_wr;
      bus_oe   = cur_wr;
      bus_addr = IO_ADDR;
      bus_dout = {{(DW-SIG_W){1'b0}}, wr_data};
    end else if (mem_cyc) begin
      rw_n     = !mem_wr;
      bus_oe   = mem_wr;
      bus_addr = mem_addr;
      bus_dout = mem_wdata;
    end else begin
      rw_n     = 1'b1;
      bus_oe   = 1'b0;
      bus_addr = '0;
      bus_dout = '0;
    end
  end
endmodule

// File: rtl/em_sig_port.sv
module em_sig_port #(
  parameter int CLK_HZ = 100_000_000,
  parameter int SIG_W = 4,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] IO_ADDR = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_cmd,
  input  logic             m_valid,
  input  logic [SIG_W-1:0] m_bits,
  output logic             e_valid,
  output logic [SIG_W-1:0] e_bits,
  input  logic             mem_req,
  input  logic             mem_wr,
  input  logic [AW-1:0]    mem_addr,
  input  logic [DW-1:0]    mem_wdata,
  output logic             mem_gnt,
  output logic             sigen_n,
  output logic             ios_n,
  output logic             ms_n,
  output logic             rw_n,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_dout,
  output logic             bus_oe,
  input  logic [SIG_W-1:0] bus_din_lo
);
  localparam int TICK_CYCLES = CLK_HZ / 1000;

  logic tick, activate, io_pend;

  em_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  em_run_ctl u_run (
    .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd),
    .sigen_n(sigen_n), .activate(activate)
  );

  em_bus_seq #(.SIG_W(SIG_W), .AW(AW), .DW(DW), .IO_ADDR(IO_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .active(!sigen_n), .activate(activate),
    .tick(tick), .m_valid(m_valid), .m_bits(m_bits),
    .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .bus_din_lo(bus_din_lo), .ios_n(ios_n), .ms_n(ms_n), .rw_n(rw_n),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .mem_gnt(mem_gnt), .e_valid(e_valid), .e_bits(e_bits), .io_pend(io_pend)
  );
endmodule

// File: rtl/em_sig_port_chk.sv
module em_sig_port_chk (
  input logic clk,
  input logic rst_n,
  input logic sigen_n,
  input logic ios_n,
  input logic ms_n,
  input logic mem_req,
  input logic e_valid,
  input logic io_pend
);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ios_n && !ms_n));

  p_mem_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && ios_n) |-> !ms_n);

  p_strobe_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ios_n) |=> !ios_n);

  p_strobe_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ios_n && $past(!ios_n)) |=> ios_n);

  p_idle_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sigen_n |-> (ios_n && !e_valid));

  p_enable_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sigen_n |=> !sigen_n);

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    e_valid |=> !e_valid);

  p_defer_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ms_n) && io_pend && !sigen_n) |=> !ios_n);
endmodule

bind em_sig_port em_sig_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sigen_n(sigen_n), .ios_n(ios_n), .ms_n(ms_n),
  .mem_req(mem_req), .e_valid(e_valid), .io_pend(io_pend)
);

// File: tb/test_em_sig_port.sv
module test_em_sig_port;
  localparam int CLK_HZ = 24000;
  localparam int SW = 4;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, run_cmd, m_valid, mem_req, mem_wr;
  logic [SW-1:0] m_bits, e_pins, bus_din_lo, e_bits;
  logic [AW-1:0] mem_addr, bus_addr;
  logic [DW-1:0] mem_wdata, bus_dout;
  logic e_valid, mem_gnt, sigen_n, ios_n, ms_n, rw_n, bus_oe;

  // External port model: E pins answer only an I/O read, junk otherwise
  assign bus_din_lo = (!ios_n && rw_n) ? e_pins : ~e_pins;

  em_sig_port #(.CLK_HZ(CLK_HZ), .SIG_W(SW), .AW(AW), .DW(DW)) i_em_sig_port (
    .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .m_valid(m_valid), .m_bits(m_bits),
    .e_valid(e_valid), .e_bits(e_bits), .mem_req(mem_req), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .sigen_n(sigen_n),
    .ios_n(ios_n), .ms_n(ms_n), .rw_n(rw_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .bus_din_lo(bus_din_lo)
  );

  function automatic int exp_gap(input int hz);
    return hz / 1000;
  endfunction

  function automatic logic [DW-1:0] exp_word(input logic [SW-1:0] m);
    logic [DW-1:0] w;
    w = '0;
    w[SW-1:0] = m;
    return w;
  endfunction

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- monitor ----------------
  int cyc = 0, n_wr = 0, n_rd = 0, n_ev = 0, ev_t0 = 0, ev_t1 = 0, run_len = 0;
  int wr_cyc = 0, n_str = 0;
  int kinds[16];
  logic [SW-1:0] last_m = '0, last_wr = '0;
  logic prev_ios = 1'b1, prev_ev = 1'b0;

  always @(posedge clk) cyc++;

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      if (mem_req) begin
        if (ios_n) begin
          chk(!ms_n && mem_gnt, "R6", "memory not granted on free bus", ms_n, 0);
          chk(bus_addr == mem_addr && rw_n == !mem_wr && bus_oe == mem_wr &&
              (!mem_wr || bus_dout == mem_wdata), "R9", "memory cycle bus", bus_addr, mem_addr);
        end else begin
          chk(ms_n, "R6", "memory strobe during I/O strobe", ms_n, 1);
        end
      end
      if (sigen_n) chk(ios_n && !e_valid, "R2", "I/O activity while inactive", ios_n, 1);
      if (!ios_n && prev_ios) begin
        kinds[n_str % 16] = rw_n ? 0 : 1;
        n_str++;
        if (!rw_n) begin
          chk(bus_oe && bus_dout == exp_word(last_m), "R5", "write data", bus_dout, exp_word(last_m));
          last_wr = bus_dout[SW-1:0];
          wr_cyc = cyc;
          n_wr++;
        end else begin
          chk(!bus_oe, "R4", "bus driven on read", bus_oe, 0);
          n_rd++;
        end
      end
      if (!ios_n) run_len++;
      if (ios_n && !prev_ios) begin
        chk(run_len == 2, "R4", "strobe length", run_len, 2);
        run_len = 0;
      end
      if (e_valid) begin
        chk(e_bits == e_pins, "R3", "sampled E bits", e_bits, e_pins);
        chk(!prev_ev, "R3", "valid longer than one cycle", 1, 0);
        ev_t0 = ev_t1;
        ev_t1 = cyc;
        n_ev++;
      end
    end else begin
      run_len = 0;
    end
    prev_ios = ios_n;
    prev_ev = e_valid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  task automatic wait_wr(input int base);
    int t = 0;
    while (n_wr <= base && t < 400) begin
      @(negedge clk);
      t++;
    end
    chk(n_wr > base, "R5", "write cycle issued", n_wr, base + 1);
  endtask

  task automatic do_run();
    @(negedge clk) run_cmd = 1'b1;
    @(negedge clk) run_cmd = 1'b0;
    chk(sigen_n == 1'b0, "R2", "enable after Run", sigen_n, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mem_req = 1'b0; m_valid = 1'b0; run_cmd = 1'b0;
    repeat (3) @(negedge clk);
    chk(sigen_n && ios_n && ms_n && !e_valid && !mem_gnt, "R1", "reset outputs",
        {sigen_n, ios_n, ms_n, e_valid, mem_gnt}, 5'b11100);
    rst_n = 1'b1;
    last_m = '0;
  endtask

  initial begin
    int base, sbase, c0, t, burst;
    void'($urandom(32'd4830));
    rst_n = 1'b0; run_cmd = 0; m_valid = 0; m_bits = '0; mem_req = 0; mem_wr = 0;
    mem_addr = '0; mem_wdata = '0; e_pins = 4'h6;
    do_reset();

    // R2: nothing happens before Run
    repeat (3 * exp_gap(CLK_HZ)) @(negedge clk);
    chk(n_rd == 0 && n_ev == 0 && n_wr == 0, "R2", "I/O before Run", n_rd + n_ev + n_wr, 0);
    chk(sigen_n == 1'b1, "R2", "enable before Run", sigen_n, 1);

    // R1/R10: first write after Run carries the reset value 0
    base = n_wr;
    do_run();
    wait_wr(base);
    chk(last_wr == 4'h0, "R1", "held M after reset", last_wr, 0);

    // R3: quiet bus, samples spaced by the tick period, value held or changed
    base = n_ev;
    t = 0;
    while (n_ev < base + 4 && t < 10 * exp_gap(CLK_HZ)) begin
      @(negedge clk);
      if (t % 30 == 29) e_pins = 4'($urandom);
      t++;
    end
    chk(n_ev >= base + 4, "R3", "sample count", n_ev - base, 4);
    chk(ev_t1 - ev_t0 == exp_gap(CLK_HZ), "R3", "sample spacing", ev_t1 - ev_t0, exp_gap(CLK_HZ));

    // R5: single update
    base = n_wr;
    @(negedge clk) begin m_valid = 1; m_bits = 4'h5; last_m = 4'h5; end
    @(negedge clk) m_valid = 0;
    wait_wr(base);
    chk(last_wr == 4'h5, "R5", "single update written", last_wr, 5);

    // R7/R8/R5: long memory hold, two updates and a tick queued behind it
    @(negedge clk) begin mem_req = 1; mem_wr = 1; mem_addr = 16'h1234; mem_wdata = 16'hBEEF; end
    repeat (3) @(negedge clk);
    m_valid = 1; m_bits = 4'h3; last_m = 4'h3;
    @(negedge clk) begin m_bits = 4'hC; last_m = 4'hC; end
    @(negedge clk) m_valid = 0;
    repeat (exp_gap(CLK_HZ) + 4) @(negedge clk);
    sbase = n_str;
    base = n_wr;
    mem_req = 0;
    c0 = cyc;
    t = 0;
    while (n_str < sbase + 2 && t < 100) begin @(negedge clk); t++; end
    chk(n_wr == base + 1 && last_wr == 4'hC, "R5", "latest update wins", last_wr, 4'hC);
    chk(kinds[sbase % 16] == 1, "R8", "first strobe after hold is write", kinds[sbase % 16], 1);
    chk(kinds[(sbase + 1) % 16] == 0, "R8", "second strobe is read", kinds[(sbase + 1) % 16], 0);
    chk(wr_cyc - c0 >= 1 && wr_cyc - c0 <= 2, "R7", "deferred write latency", wr_cyc - c0, 1);

    // Random traffic
    base = n_ev;
    burst = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (burst > 0) burst--;
      else if ($urandom % 8 == 0) burst = int'($urandom % 5) + 1;
      mem_req = (burst > 0);
      mem_wr = 1'($urandom);
      mem_addr = 16'($urandom);
      mem_wdata = 16'($urandom);
      m_valid = ($urandom % 16 == 0);
      if (m_valid) begin m_bits = 4'($urandom); last_m = m_bits; end
      if ($urandom % 10 == 0) e_pins = 4'($urandom);
    end
    @(negedge clk) begin mem_req = 0; m_valid = 0; end
    chk(n_ev - base > 50, "R3", "samples under traffic", n_ev - base, 50);

    // R1: reset while active, then R10 with an update before Run
    do_reset();
    repeat (2 * exp_gap(CLK_HZ)) @(negedge clk);
    chk(sigen_n == 1'b1, "R2", "enable after second reset", sigen_n, 1);
    @(negedge clk) begin m_valid = 1; m_bits = 4'hB; last_m = 4'hB; end
    @(negedge clk) m_valid = 0;
    repeat (5) @(negedge clk);
    chk(ios_n == 1'b1, "R2", "update before Run stays off bus", ios_n, 1);
    base = n_wr;
    do_run();
    wait_wr(base);
    chk(last_wr == 4'hB, "R10", "pre-Run update sent at activation", last_wr, 4'hB);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule